// File: doc/BRIEF.md
# Branch-Operand Chain Tracker for an Integer Register File

This block holds a small integer register file and decides which value a conditional branch receives as its comparison operand. Each cycle it may accept one decoded instruction descriptor. The descriptor carries two source register fields, a destination register field and a few flags: whether the sources are read, whether the destination is written, and whether the written value comes from a flag read. It also carries a stall marker, an instruction kind, and the result value to be written.

A write to a register opens a chain on that register. Each following instruction that both reads and writes the same register lengthens the chain, up to a fixed maximum length. While a chain is open, a conditional branch that names the register sees the value the register held before the chain began. Register-indirect jumps always see the live value. A write made by a flag-read instruction does not open a chain, so a later branch sees the new value at once.

Top module: `chain_branch_rf`

## Requirements
- R1: Register fields are 5 bits wide. Only the low 4 bits select a register, so a field value of 18 addresses register 2.
- R2: Register 0 always reads as 0 on both operands. Writes addressed to it, including through field value 16, are dropped and open no chain.
- R3: A conditional branch (kind 1) issued right after a plain write to a register sees that register's value from before the write.
- R4: An instruction that writes a register, reads it as a source and follows an open chain on it extends the chain. A conditional branch then still sees the value from before the chain's first write.
- R5: A chain holds at most 4 instructions. A fifth consecutive read-and-write instruction opens a new chain, so a branch after it sees the value produced by the fourth.
- R6: Register-indirect jumps (kind 2 plain, kind 3 linking) always see the current register value.
- R7: A write marked as a flag read opens no chain, so a following conditional branch sees the newly written value.
- R8: Any valid instruction that does not both read and write a chained register closes that chain, so a later branch sees the current value.
- R9: An instruction marked as stalled that would extend a chain opens a new chain at itself, and a branch then sees the value from just before that instruction.
- R10: Cycles with the valid input low change neither register contents nor chain state.
- R11: After reset, every register reads 0 and no chain is open.
- R12: The second operand follows the same selection rules as the first. Instruction kind 0 (not a branch or jump) presents the current values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Descriptor present this cycle |
| ins_src_a | input | 5 | First source register field |
| ins_src_b | input | 5 | Second source register field |
| ins_dst | input | 5 | Destination register field |
| ins_reads | input | 1 | Instruction reads its source registers |
| ins_writes | input | 1 | Instruction writes its destination |
| ins_flag | input | 1 | Written value comes from a flag read |
| ins_stall | input | 1 | Instruction entered after a pipeline stall |
| ins_kind | input | 2 | 0 other, 1 conditional branch, 2 jump, 3 jump and link |
| ins_wdata | input | 16 | Value written to the destination |
| opnd_a | output | 16 | Operand for the first source |
| opnd_b | output | 16 | Operand for the second source |

## Verification
The bench builds the block with its defaults: 16 registers of 16 bits, 5-bit fields and a maximum chain length of 4. It draws random register fields from a small set of low indices, with the top field bit set at random. This makes chains long enough to hit the four-instruction cap, aliasing through the masked bit, and writes to register 0 frequent. It also mixes in flag reads, stalls and idle cycles. Directed sequences cover each requirement, including a loop in which the chain opened by the delay-slot write is extended on the next pass.

// File: rtl/chain_branch_rf.sv
module chain_branch_rf #(
  parameter int W      = 16,
  parameter int NREG   = 16,
  parameter int FW     = 5,
  parameter int MAXLEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [FW-1:0] ins_src_a,
  input  logic [FW-1:0] ins_src_b,
  input  logic [FW-1:0] ins_dst,
  input  logic          ins_reads,
  input  logic          ins_writes,
  input  logic          ins_flag,
  input  logic          ins_stall,
  input  logic [1:0]    ins_kind,
  input  logic [W-1:0]  ins_wdata,
  output logic [W-1:0]  opnd_a,
  output logic [W-1:0]  opnd_b
);
  localparam int AW = $clog2(NREG);
  localparam int LW = $clog2(MAXLEN + 1);
  localparam logic [1:0] K_BR = 2'd1;

  logic [W-1:0]  rf    [NREG];
  logic [W-1:0]  saved [NREG];
  logic [LW-1:0] len   [NREG];
  logic [NREG-1:0] act;

  wire [AW-1:0] sa = ins_src_a[AW-1:0];
  wire [AW-1:0] sb = ins_src_b[AW-1:0];
  wire [AW-1:0] da = ins_dst[AW-1:0];

  wire rw_same = ins_reads && (sa == da || sb == da);
  wire wr_en   = ins_valid && ins_writes && da != '0;
  wire extend  = wr_en && !ins_flag && !ins_stall && rw_same && act[da]
                 && len[da] != LW'(MAXLEN);
  wire is_br   = ins_kind == K_BR;
  wire [W-1:0] old_dst = rf[da];

  function automatic logic [W-1:0] pick(input logic [AW-1:0] idx, input logic br);
    if (idx == '0)            return '0;
    else if (br && act[idx])  return saved[idx];
    else                      return rf[idx];
  endfunction

  assign opnd_a = pick(sa, is_br);
  assign opnd_b = pick(sb, is_br);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        rf[r]    <= '0;
        saved[r] <= '0;
        len[r]   <= '0;
      end
      act <= '0;
    end else if (ins_valid) begin
      act <= '0;
      if (wr_en) begin
        rf[da] <= ins_wdata;
        if (extend) begin
          act[da] <= 1'b1;
          len[da] <= len[da] + LW'(1);
        end else if (!ins_flag) begin
          act[da]   <= 1'b1;
          len[da]   <= LW'(1);
          saved[da] <= rf[da];
        end
      end
    end
  end

  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && sa == '0 |-> opnd_a == '0);

  p_plain_old_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !ins_flag && !extend) && ins_valid && is_br && sa == $past(da)
    |-> opnd_a == $past(old_dst));

  p_jump_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) && ins_valid && ins_kind[1] && sa == $past(da)
    |-> opnd_a == $past(ins_wdata));

  p_flag_new_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && ins_flag) && ins_valid && is_br && sa == $past(da)
    |-> opnd_a == $past(ins_wdata));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> $stable(act));
endmodule

// File: tb/sim_chain_branch_rf.sv
`timescale 1ns/1ps
module sim_chain_branch_rf;
  logic clk = 0, rst_n = 0;
  logic ins_valid = 0, ins_reads = 0, ins_writes = 0, ins_flag = 0, ins_stall = 0;
  logic [4:0] ins_src_a = 0, ins_src_b = 0, ins_dst = 0;
  logic [1:0] ins_kind = 0;
  logic [15:0] ins_wdata = 0;
  logic [15:0] opnd_a, opnd_b;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  chain_branch_rf u0 (.clk, .rst_n, .ins_valid, .ins_src_a, .ins_src_b, .ins_dst,
    .ins_reads, .ins_writes, .ins_flag, .ins_stall, .ins_kind, .ins_wdata,
    .opnd_a, .opnd_b);

  logic [15:0] m_rf [16];
  logic [15:0] m_sv [16];
  int m_len [16];
  bit m_act [16];

  function automatic logic [15:0] mread(input logic [4:0] f, input logic [1:0] k);
    int i = int'(f & 5'hF);
    if (i == 0) return 16'h0;
    if (k == 2'd1 && m_act[i]) return m_sv[i];
    return m_rf[i];
  endfunction

  task automatic mreset();
    for (int i = 0; i < 16; i++) begin
      m_rf[i] = 0; m_sv[i] = 0; m_len[i] = 0; m_act[i] = 0;
    end
  endtask

  task automatic check(input string tag, input logic [15:0] act_v, input logic [15:0] exp_v);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  task automatic step(input bit v, input logic [4:0] a, input logic [4:0] b,
                      input logic [4:0] d, input bit rd, input bit wr, input bit fl,
                      input bit st, input logic [1:0] k, input logic [15:0] wd,
                      input string tag);
    int di;
    bit rw, ext;
    @(negedge clk);
    ins_valid = v; ins_src_a = a; ins_src_b = b; ins_dst = d; ins_reads = rd;
    ins_writes = wr; ins_flag = fl; ins_stall = st; ins_kind = k; ins_wdata = wd;
    #1;
    check(tag, opnd_a, mread(a, k));
    check({tag, "/R12"}, opnd_b, mread(b, k));
    if (v) begin
      di = int'(d & 5'hF);
      rw = rd && ((a & 5'hF) == di || (b & 5'hF) == di);
      ext = wr && di != 0 && !fl && !st && rw && m_act[di] && m_len[di] != 4;
      for (int i = 0; i < 16; i++) m_act[i] = 0;
      if (wr && di != 0) begin
        if (ext) begin
          m_act[di] = 1; m_len[di]++;
        end else if (!fl) begin
          m_act[di] = 1; m_len[di] = 1; m_sv[di] = m_rf[di];
        end
        m_rf[di] = wd;
      end
    end
  endtask

  task automatic wr(input logic [4:0] d, input bit rd, input logic [15:0] wd, input string tag);
    step(1, d, 5'd0, d, rd, 1, 0, 0, 2'd0, wd, tag);
  endtask

  task automatic br(input logic [4:0] a, input logic [4:0] b, input string tag);
    step(1, a, b, 5'd0, 1, 0, 0, 0, 2'd1, 16'h0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    mreset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int r = 0; r < 16; r++) br(5'(r), 5'(r + 16), "R11 reset");
    for (int r = 0; r < 16; r++) step(1, 5'(r), 5'(r), 0, 1, 0, 0, 0, 2'd2, 0, "R11 reset");

    wr(5'd18, 0, 16'h1234, "R1 masked write");
    br(5'd18, 5'd2, "R1 masked branch");
    step(1, 5'd2, 5'd18, 0, 1, 0, 0, 0, 2'd2, 0, "R1 R6 jump");

    wr(5'd16, 0, 16'hBEEF, "R2 write r0");
    br(5'd0, 5'd16, "R2 read r0");
    wr(5'd0, 1, 16'hBEEF, "R2 write r0");
    step(1, 5'd16, 5'd0, 0, 1, 0, 0, 0, 2'd3, 0, "R2 jump r0");

    wr(5'd5, 0, 16'd100, "R3 plain");
    br(5'd5, 5'd0, "R3 branch");
    wr(5'd5, 0, 16'd100, "R4 start");
    wr(5'd5, 1, 16'd200, "R4 ext");
    wr(5'd5, 1, 16'd300, "R4 ext");
    wr(5'd5, 1, 16'd400, "R4 ext");
    br(5'd5, 5'd21, "R4 full chain");
    for (int i = 0; i < 5; i++) wr(5'd5, 1, 16'(500 + i), "R5 run");
    br(5'd5, 5'd5, "R5 fifth");

    wr(5'd5, 0, 16'h0777, "R6 write");
    step(1, 5'd5, 5'd5, 0, 1, 0, 0, 0, 2'd2, 0, "R6 jump");
    wr(5'd5, 0, 16'h0888, "R6 write");
    step(1, 5'd5, 5'd5, 5'd0, 1, 0, 0, 0, 2'd3, 0, "R6 link");

    step(1, 0, 0, 5'd6, 0, 1, 1, 0, 2'd0, 16'hABCD, "R7 flag write");
    br(5'd6, 5'd22, "R7 branch");

    wr(5'd7, 0, 16'd1, "R8 write");
    wr(5'd8, 0, 16'd2, "R8 other");
    br(5'd7, 5'd8, "R8 branch");

    wr(5'd9, 0, 16'd11, "R9 start");
    step(1, 5'd9, 0, 5'd9, 1, 1, 0, 1, 2'd0, 16'd22, "R9 stall");
    br(5'd9, 5'd25, "R9 branch");

    wr(5'd10, 0, 16'd33, "R10 write");
    step(0, 5'd10, 5'd10, 5'd10, 1, 1, 0, 0, 2'd1, 16'd99, "R10 idle");
    step(0, 5'd10, 5'd3, 5'd10, 1, 1, 1, 1, 2'd0, 16'd77, "R10 idle");
    br(5'd10, 5'd10, "R10 branch");

    wr(5'd3, 0, 16'd251, "R4 loop init");
    for (int pass = 0; pass < 3; pass++) begin
      for (int i = 0; i < 3; i++) wr(5'd2, 1, 16'(pass * 16 + i + 1), "R4 loop body");
      br(5'd3, 5'd2, "R4 loop branch");
      wr(5'd2, 1, 16'(pass * 16 + 9), "R4 delay slot");
    end

    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 9);
      logic [4:0] a = 5'({$urandom_range(0, 1), 4'($urandom_range(0, 3))});
      logic [4:0] b = 5'({$urandom_range(0, 1), 4'($urandom_range(0, 3))});
      logic [4:0] d = (sel < 5) ? a : 5'({$urandom_range(0, 1), 4'($urandom_range(0, 3))});
      logic [1:0] k = (sel == 6 || sel == 7) ? 2'd1 : (sel == 8 ? 2'($urandom_range(2, 3)) : 2'd0);
      bit v = $urandom_range(0, 15) != 0;
      step(v, a, b, d, $urandom_range(0, 3) != 0, k == 0, $urandom_range(0, 7) == 0,
           $urandom_range(0, 9) == 0, k, 16'($urandom), "R4 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule